// File: doc/BRIEF.md
# DMA Arbiter With Refresh Channel

This block decides which of four DMA channels owns the system bus and then paces that channel's bus cycle. Channel 0 is fixed as the dynamic-memory refresh engine. An external timer drives a periodic tick into it, and the block stores the tick as a pending refresh. When that refresh is served, the block runs a dummy memory-read cycle in which no data moves. Channels 1 to 3 belong to I/O devices. Each one raises a level request and is served with a full transfer cycle between the device and memory. The processor takes no part in these transfers.

When a request is pending, the block asks the processor for the bus. When the grant arrives, it chooses the winner by fixed priority and sends the winner a one-clock acknowledge. It then drives cycle-type outputs for the length of the cycle. A refresh cycle always lasts four clocks. A data-transfer cycle lasts five clocks, and the processor-ready input can stretch it with wait states. The block does not program addresses or counts.

Top module: `dma_refresh_arb`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `bus_req`, `chan_ack`, `cyc_active`, `cyc_refresh` and `cyc_xfer` are all low.
- R2: When the block is idle and a request is pending (a stored refresh or any `dev_req` bit high), `bus_req` rises at the next clock edge. It stays high until the bus cycle ends, and it falls once no request is left.
- R3: No bus cycle starts while `bus_grant` is low. During that time `bus_req` stays high and `chan_ack` stays zero.
- R4: Priority is fixed: refresh channel 0 first, then 1, then 2, then 3. The choice is made in the clock in which the grant is seen.
- R5: A granted channel i receives a single-clock pulse on `chan_ack[i]`, and the bit index equals the channel number. The pulse falls in the first clock of its bus cycle. At most one bit is high at a time.
- R6: A data transfer on channel 1, 2 or 3 holds `cyc_active` and `cyc_xfer` high for 5 clocks when `cpu_ready` stays high. During that time `cyc_chan` equals the channel number.
- R7: The block samples `cpu_ready` in the third clock of a data transfer. Each clock in which it is low at that point adds one wait clock to the cycle.
- R8: A refresh cycle holds `cyc_active` and `cyc_refresh` high for exactly 4 clocks, with `cyc_chan` = 0. `cpu_ready` has no effect on its length.
- R9: Any number of refresh ticks that arrive while a refresh is already pending merge into one refresh cycle.
- R10: The pending refresh is cleared in the clock in which it is granted. A tick in that clock or later starts a further refresh cycle.
- R11: `cyc_refresh` and `cyc_xfer` are never high together. One of them is high whenever `cyc_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_tick | input | 1 | Periodic single-clock refresh request from the timer |
| dev_req | input | 3 | Level requests of channels 1..3 (bit 0 = channel 1) |
| bus_grant | input | 1 | Processor has released the bus |
| cpu_ready | input | 1 | Low stretches a data transfer with wait clocks |
| bus_req | output | 1 | Request for the bus to the processor |
| chan_ack | output | 4 | One-clock acknowledge; bit i = channel i |
| cyc_active | output | 1 | A DMA bus cycle is in progress |
| cyc_refresh | output | 1 | The current cycle is a dummy refresh read |
| cyc_xfer | output | 1 | The current cycle is a data transfer |
| cyc_chan | output | 2 | Channel that owns the current cycle |

## Verification
The timer tick and the device requests can arrive in the same clock. The bench raises a refresh tick and the requests of channels 2 and 3 on one clock edge. It then expects the cycles to come out as refresh, channel 2 and channel 3, each with the right acknowledge bit and the right length. A tick can also land in the first clock of a refresh that is already granted. The bench provokes this and expects a second refresh cycle after the first. In a separate case, two ticks arrive while the grant is withheld, and the bench expects exactly one refresh cycle.

// File: rtl/dmaa_pkg.sv
package dmaa_pkg;

    localparam int NUM_CH     = 4;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int REFRESH_CH = 0;

    typedef logic [CH_W-1:0] chan_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CYC  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        chan_t      chan;
    } seq_reg_t;

    function automatic logic chan_is_refresh(chan_t c);
        return c == chan_t'(REFRESH_CH);
    endfunction

    function automatic logic [NUM_CH-1:0] chan_onehot(chan_t c);
        return NUM_CH'(1) << c;
    endfunction

endpackage

// File: rtl/dmaa_refresh_latch.sv
module dmaa_refresh_latch (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic taken,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else begin
            pending <= tick | (pending & ~taken);
        end
    end
endmodule

// File: rtl/dmaa_prio_pick.sv
module dmaa_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] shadowed;
    logic [N-1:0] won;

    assign shadowed[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign shadowed[i] = shadowed[i-1] | req[i-1];
    end

    assign won = req & ~shadowed;
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (won[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dmaa_cycle_seq.sv
module dmaa_cycle_seq
    import dmaa_pkg::*;
#(
    parameter int XFER_CLKS    = 5,
    parameter int REFRESH_CLKS = 4,
    parameter int WAIT_SLOT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_req,
    input  chan_t             winner,
    input  logic              bus_grant,
    input  logic              cpu_ready,
    output logic              take,
    output seq_reg_t          cur,
    output logic [NUM_CH-1:0] ack
);
    localparam int MAX_CLKS = (XFER_CLKS > REFRESH_CLKS) ? XFER_CLKS : REFRESH_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    logic [CNT_W-1:0] cnt;
    logic             is_ref;
    logic             stall;
    logic             last;

    assign is_ref = chan_is_refresh(cur.chan);
    assign stall  = !is_ref && (cnt == CNT_W'(WAIT_SLOT)) && !cpu_ready;
    assign last   = is_ref ? (cnt == CNT_W'(REFRESH_CLKS - 1))
                           : (cnt == CNT_W'(XFER_CLKS - 1));
    assign take   = (cur.st == ST_HOLD) && any_req && bus_grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st   <= ST_IDLE;
            cur.chan <= '0;
            cnt      <= '0;
            ack      <= '0;
        end else begin
            ack <= '0;
            unique case (cur.st)
                ST_IDLE: begin
                    if (any_req) cur.st <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!any_req) begin
                        cur.st <= ST_IDLE;
                    end else if (bus_grant) begin
                        cur.st   <= ST_CYC;
                        cur.chan <= winner;
                        cnt      <= '0;
                        ack      <= chan_onehot(winner);
                    end
                end
                ST_CYC: begin
                    if (!stall) begin
                        if (last) begin
                            cur.st <= ST_IDLE;
                            cnt    <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: cur.st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_refresh_arb.sv
module dma_refresh_arb
    import dmaa_pkg::*;
#(
    parameter int XFER_CLKS    = 5,
    parameter int REFRESH_CLKS = 4,
    parameter int WAIT_SLOT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh_tick,
    input  logic [NUM_CH-2:0] dev_req,
    input  logic              bus_grant,
    input  logic              cpu_ready,
    output logic              bus_req,
    output logic [NUM_CH-1:0] chan_ack,
    output logic              cyc_active,
    output logic              cyc_refresh,
    output logic              cyc_xfer,
    output logic [CH_W-1:0]   cyc_chan
);
    logic              ref_pending;
    logic              take;
    logic              any_req;
    chan_t             winner;
    logic [NUM_CH-1:0] req_vec;
    seq_reg_t          cur;

    assign req_vec = {dev_req, ref_pending};

    dmaa_refresh_latch u_ref (
        .clk     (clk),
        .rst     (rst),
        .tick    (refresh_tick),
        .taken   (take && chan_is_refresh(winner)),
        .pending (ref_pending)
    );

    dmaa_prio_pick #(.N(NUM_CH)) u_pick (
        .req (req_vec),
        .any (any_req),
        .idx (winner)
    );

    dmaa_cycle_seq #(
        .XFER_CLKS    (XFER_CLKS),
        .REFRESH_CLKS (REFRESH_CLKS),
        .WAIT_SLOT    (WAIT_SLOT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .any_req   (any_req),
        .winner    (winner),
        .bus_grant (bus_grant),
        .cpu_ready (cpu_ready),
        .take      (take),
        .cur       (cur),
        .ack       (chan_ack)
    );

    assign bus_req     = cur.st != ST_IDLE;
    assign cyc_active  = cur.st == ST_CYC;
    assign cyc_refresh = cyc_active && chan_is_refresh(cur.chan);
    assign cyc_xfer    = cyc_active && !chan_is_refresh(cur.chan);
    assign cyc_chan    = cur.chan;
endmodule

// File: rtl/dmaa_checker.sv
module dmaa_checker #(
    parameter int XFER_CLKS    = 5,
    parameter int REFRESH_CLKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_grant,
    input logic       bus_req,
    input logic [3:0] chan_ack,
    input logic       cyc_active,
    input logic       cyc_refresh,
    input logic       cyc_xfer
);
    logic [7:0] ref_run;
    logic [7:0] xfer_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_run  <= '0;
            xfer_run <= '0;
        end else begin
            ref_run  <= cyc_refresh ? ((ref_run == 8'hFF) ? ref_run : ref_run + 1'b1) : 8'd0;
            xfer_run <= cyc_xfer ? ((xfer_run == 8'hFF) ? xfer_run : xfer_run + 1'b1) : 8'd0;
        end
    end

    p_ack_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_ack));
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_ack != 4'd0) |=> (chan_ack == 4'd0));
    p_ack_in_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_ack != 4'd0) |-> (cyc_active && $rose(cyc_active)));
    p_start_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_active) |-> $past(bus_grant));
    p_req_covers_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        cyc_active |-> bus_req);
    p_type_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(cyc_refresh && cyc_xfer));
    p_type_present_r11: assert property (@(posedge clk) disable iff (rst)
        cyc_active |-> (cyc_refresh || cyc_xfer));
    p_refresh_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cyc_refresh) |-> (ref_run == 8'(REFRESH_CLKS)));
    p_xfer_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cyc_xfer) |-> (xfer_run >= 8'(XFER_CLKS)));
endmodule

bind dma_refresh_arb dmaa_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_grant   (bus_grant),
    .bus_req     (bus_req),
    .chan_ack    (chan_ack),
    .cyc_active  (cyc_active),
    .cyc_refresh (cyc_refresh),
    .cyc_xfer    (cyc_xfer)
);

// File: tb/dma_refresh_arb_tb.sv
module dma_refresh_arb_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       refresh_tick = 1'b0;
    logic [2:0] dev_req;
    logic       bus_grant = 1'b1;
    logic       cpu_ready = 1'b1;
    logic       bus_req;
    logic [3:0] chan_ack;
    logic       cyc_active, cyc_refresh, cyc_xfer;
    logic [1:0] cyc_chan;

    always #10 clk = ~clk;

    dma_refresh_arb u_dut (
        .clk(clk), .rst(rst), .refresh_tick(refresh_tick), .dev_req(dev_req),
        .bus_grant(bus_grant), .cpu_ready(cpu_ready), .bus_req(bus_req),
        .chan_ack(chan_ack), .cyc_active(cyc_active), .cyc_refresh(cyc_refresh),
        .cyc_xfer(cyc_xfer), .cyc_chan(cyc_chan)
    );

    typedef struct { int ch; int len; string tag; } exp_t;
    exp_t q[$];

    int raise_cnt [1:3] = '{0, 0, 0};
    int serve_cnt [1:3] = '{0, 0, 0};
    always_comb begin
        for (int i = 1; i <= 3; i++) dev_req[i-1] = raise_cnt[i] != serve_cnt[i];
    end

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  open_rec = 0;
    bit  done     = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: pops an expected item per acknowledge and measures the cycle
    initial begin
        exp_t cur;
        int   len = 0;
        forever begin
            @(negedge clk);
            if (!rst && chan_ack != 4'd0) begin
                if (q.size() == 0) begin
                    check(0, "R9", "unexpected acknowledge", int'(chan_ack), 0);
                end else begin
                    cur = q.pop_front();
                    check(chan_ack == (4'd1 << cur.ch), "R4", "ack vector", int'(chan_ack), 1 << cur.ch);
                    check(int'(cyc_chan) == cur.ch, "R5", "cycle channel", int'(cyc_chan), cur.ch);
                    check(cyc_refresh == (cur.ch == 0) && cyc_xfer == (cur.ch != 0),
                          "R11", "cycle type", int'({cyc_refresh, cyc_xfer}), (cur.ch == 0) ? 2 : 1);
                    if (cur.ch != 0) serve_cnt[cur.ch]++;
                    open_rec = 1;
                    len = 1;
                end
            end else if (open_rec && cyc_active) begin
                len++;
            end else if (open_rec) begin
                check(len == cur.len, cur.tag, "cycle length", len, cur.len);
                open_rec = 0;
            end
        end
    end

    task automatic expect_item(int ch, int len, string tag);
        exp_t e;
        e.ch = ch; e.len = len; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick_pulse();
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        int k = 0;
        while ((q.size() != 0 || open_rec || bus_req || cyc_active) && k < 300) begin
            @(negedge clk);
            k++;
        end
        check(k < 300, tag, "return to idle", k, 0);
    endtask

    task automatic wait_ack(int ch);
        int k = 0;
        while (!chan_ack[ch] && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_req && chan_ack == 0 && !cyc_active && !cyc_refresh && !cyc_xfer,
              "R1", "outputs in reset", int'({bus_req, chan_ack, cyc_active}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && chan_ack == 0 && !cyc_active, "R1", "outputs after reset",
              int'({bus_req, chan_ack, cyc_active}), 0);

        // single transfer on channel 1 (R2, R6)
        expect_item(1, 5, "R6");
        raise_cnt[1]++;
        @(negedge clk);
        check(bus_req, "R2", "bus_req one clock after request", int'(bus_req), 1);
        wait_idle("R2");
        check(!bus_req, "R2", "bus_req low when nothing pending", int'(bus_req), 0);

        // single refresh
        expect_item(0, 4, "R8");
        tick_pulse();
        wait_idle("R8");

        // grant withheld (R3)
        bus_grant = 1'b0;
        expect_item(3, 5, "R6");
        raise_cnt[3]++;
        repeat (6) @(negedge clk);
        check(bus_req && !cyc_active && chan_ack == 0, "R3", "no cycle without grant",
              int'({bus_req, cyc_active}), 2);
        bus_grant = 1'b1;
        wait_idle("R3");

        // tick and two device requests on one edge (R4)
        expect_item(0, 4, "R8");
        expect_item(2, 5, "R6");
        expect_item(3, 5, "R6");
        refresh_tick = 1'b1;
        raise_cnt[2]++;
        raise_cnt[3]++;
        @(negedge clk);
        refresh_tick = 1'b0;
        wait_idle("R4");

        // channels 1 and 3 together (R4)
        expect_item(1, 5, "R4");
        expect_item(3, 5, "R4");
        raise_cnt[1]++;
        raise_cnt[3]++;
        wait_idle("R4");

        // wait states on a transfer (R7): ready returns five clocks after ack
        cpu_ready = 1'b0;
        expect_item(2, 8, "R7");
        raise_cnt[2]++;
        wait_ack(2);
        repeat (5) @(negedge clk);
        cpu_ready = 1'b1;
        wait_idle("R7");

        // ready low during refresh has no effect (R8)
        cpu_ready = 1'b0;
        expect_item(0, 4, "R8");
        tick_pulse();
        wait_idle("R8");
        cpu_ready = 1'b1;

        // two ticks while pending merge into one refresh (R9)
        bus_grant = 1'b0;
        expect_item(0, 4, "R9");
        tick_pulse();
        @(negedge clk);
        tick_pulse();
        repeat (2) @(negedge clk);
        bus_grant = 1'b1;
        wait_idle("R9");
        repeat (4) @(negedge clk);
        check(!bus_req && q.size() == 0, "R9", "no second refresh", int'(bus_req), 0);

        // tick in the first clock of a granted refresh gives another (R10)
        expect_item(0, 4, "R10");
        tick_pulse();
        wait_ack(0);
        expect_item(0, 4, "R10");
        tick_pulse();
        wait_idle("R10");

        done = 1;
        summary();
    end
endmodule